// File: doc/BRIEF.md
# Masked-Write PHY Control Register Bank

This block holds the configuration of a storage-card PHY behind a simple memory-mapped port with single-cycle read and write strobes. There are seven 32-bit control words, of which only the low 16 bits hold state. On every write, the upper 16 bits of the data act as a per-bit enable. Software can therefore flip one field, such as the DLL enable, without first reading the word back.

Two of the control words are decoded into named fields that drive the PHY: power-up, DLL enable, drive strength, output tap delay and DLL frequency band. A read-only status word at a separate offset shows two live PHY indications, calibration complete and DLL locked. Each passes through a two-flop synchronizer before it can be read.

Top module: `phy_ctl_bank`

## Requirements
- R1: On a write to a control word, stored bit x (x in 0..15) takes data bit x when data bit x+16 is 1, and otherwise keeps its value; a write with all upper bits zero changes nothing.
- R2: Control word k (k = 0..6) is addressed at byte offset 4*k, that is 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18, and each word is stored independently.
- R3: A read of a control word returns its 16 stored bits in data bits 15:0, with bits 31:16 zero; read data is combinational from the address while the read strobe is high, and zero otherwise.
- R4: The status word at byte offset 0x20 returns calibration-complete at bit 6 and DLL-locked at bit 5, with all other bits zero; a change on either input becomes readable after the second rising clock edge and not after the first.
- R5: Writes to offset 0x20, to 0x1C, to 0x24 and above, and to any offset that is not a multiple of four change no stored bit and no PHY output.
- R6: After reset every stored control bit is zero, so the PHY is powered down, the DLL is disabled, the drive code is 0 and every PHY output is zero.
- R7: Control word 6 drives power-up from bit 0, DLL enable from bit 1, and the 3-bit drive-strength code from bits 6:4; codes are 0 = 50 ohm, 1 = 33 ohm, 2 = 66 ohm, 3 = 100 ohm, 4 = 40 ohm.
- R8: Control word 0 drives the 4-bit output tap delay select from bits 10:7, the tap delay enable from bit 11 and the 2-bit DLL band from bits 13:12; bands are 0 = 200 MHz, 1 = 50 MHz, 2 = 100 MHz, 3 = 150 MHz.
- R9: Reads of unmapped offsets (0x1C, 0x24 and above, or not a multiple of four) return zero.
- R10: When a read and a write strike the same control word in the same cycle, the read returns the old value and the new value is readable from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read strobe, data returned in the same cycle |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data: low half value, high half bit enables |
| bus_rdata | output | 32 | Read data |
| cal_done_async | input | 1 | Calibration complete from the PHY, asynchronous |
| dll_lock_async | input | 1 | DLL locked from the PHY, asynchronous |
| pwr_up | output | 1 | PHY analog power-up (0 = powered down) |
| dll_on | output | 1 | DLL enable |
| drv_code | output | 3 | Output drive strength code |
| tap_sel | output | 4 | Output tap delay select |
| tap_en | output | 1 | Output tap delay enable |
| dll_band | output | 2 | DLL frequency band code |

## Verification
Every cycle, the assertions check the per-bit masked update of each word: masked bits load and unmasked bits hold. They also check that at most one word decodes for an address and that writes which hit no word leave the whole store unchanged. With the default depth, they check that the synchronizer output equals the input from two edges earlier. Only the directed scenarios show the mapping of offsets to words and of bits to PHY fields, the zero returned for holes and for unaligned offsets, the read-before-write ordering in a shared cycle, and the exact status latency as seen at the read port.

// File: rtl/pc_pkg.sv
package pc_pkg;

   localparam int FIELD_W = 16;
   localparam int BUS_W   = 2 * FIELD_W;

   // word indices that carry decoded PHY fields
   localparam int IDX_TIMING = 0;
   localparam int IDX_POWER  = 6;

   // power word layout
   localparam int PWR_BIT     = 0;
   localparam int DLL_BIT     = 1;
   localparam int DRV_LSB     = 4;
   localparam int DRV_W       = 3;

   // timing word layout
   localparam int TAP_SEL_LSB = 7;
   localparam int TAP_SEL_W   = 4;
   localparam int TAP_EN_BIT  = 11;
   localparam int BAND_LSB    = 12;
   localparam int BAND_W      = 2;

   // status word layout
   localparam int ST_LOCK_BIT = 5;
   localparam int ST_CAL_BIT  = 6;

   typedef enum logic [DRV_W-1:0] {
      DRV_50R  = 3'd0,
      DRV_33R  = 3'd1,
      DRV_66R  = 3'd2,
      DRV_100R = 3'd3,
      DRV_40R  = 3'd4
   } drv_code_e;

   typedef enum logic [BAND_W-1:0] {
      BAND_200M = 2'd0,
      BAND_50M  = 2'd1,
      BAND_100M = 2'd2,
      BAND_150M = 2'd3
   } dll_band_e;

endpackage

// File: rtl/pc_mask_reg.sv
module pc_mask_reg #(
   parameter int              W       = 16,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] din,
   input  logic [W-1:0] bit_en,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_width
         $error("pc_mask_reg: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST_VAL;
      end else if (we) begin
         q <= (q & ~bit_en) | (din & bit_en);
      end
   end

   // enabled bits take the written value
   assert_masked_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((q & $past(bit_en)) == ($past(din) & $past(bit_en))));

   // bits without enable keep their value
   assert_unmasked_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((q & ~$past(bit_en)) == ($past(q) & ~$past(bit_en))));

   // no strobe, no change
   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

endmodule

// File: rtl/pc_sync.sv
module pc_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("pc_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("pc_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

   generate
      if (STAGES == 2) begin : g_chk_two
         logic [1:0] warm;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               warm <= 2'd0;
            end else if (warm != 2'd2) begin
               warm <= warm + 2'd1;
            end
         end
         assert_sync_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (warm == 2'd2) |-> (q == $past(d, 2)));
      end
   endgenerate

endmodule

// File: rtl/pc_addr_decode.sv
module pc_addr_decode #(
   parameter int ADDR_W     = 6,
   parameter int NUM_CTRL   = 7,
   parameter int STATUS_OFS = 32
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_CTRL-1:0] ctrl_sel,
   output logic                status_hit
);

   localparam int SPAN = 1 << ADDR_W;

   generate
      if (NUM_CTRL * 4 > SPAN) begin : g_bad_span
         $error("pc_addr_decode: control words exceed address span");
      end
      if (STATUS_OFS >= SPAN || (STATUS_OFS % 4) != 0) begin : g_bad_status
         $error("pc_addr_decode: status offset out of span or unaligned");
      end
      for (genvar k = 0; k < NUM_CTRL; k++) begin : g_sel
         assign ctrl_sel[k] = (addr == ADDR_W'(k * 4));
      end
   endgenerate

   assign status_hit = (addr == ADDR_W'(STATUS_OFS));

endmodule

// File: rtl/phy_ctl_bank.sv
module phy_ctl_bank
   import pc_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int NUM_CTRL    = 7,
   parameter int STATUS_OFS  = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              cal_done_async,
   input  logic              dll_lock_async,
   output logic              pwr_up,
   output logic              dll_on,
   output logic [2:0]        drv_code,
   output logic [3:0]        tap_sel,
   output logic              tap_en,
   output logic [1:0]        dll_band
);

   localparam int ST_W = 2;

   generate
      if (NUM_CTRL <= IDX_POWER) begin : g_bad_count
         $error("phy_ctl_bank: NUM_CTRL too small for the power word");
      end
      if (STATUS_OFS < NUM_CTRL * 4) begin : g_bad_overlap
         $error("phy_ctl_bank: status offset overlaps control words");
      end
      if (BUS_W != 32) begin : g_bad_bus
         $error("phy_ctl_bank: bus width must be 32");
      end
   endgenerate

   // ---------------- decode ----------------
   logic [NUM_CTRL-1:0] ctrl_sel;
   logic                status_hit;

   pc_addr_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_CTRL  (NUM_CTRL),
      .STATUS_OFS(STATUS_OFS)
   ) u_dec (
      .addr      (bus_addr),
      .ctrl_sel  (ctrl_sel),
      .status_hit(status_hit)
   );

   // ---------------- storage ----------------
   logic [NUM_CTRL-1:0][FIELD_W-1:0] ctrl_q;
   logic [FIELD_W-1:0]               wr_val;
   logic [FIELD_W-1:0]               wr_en_bits;

   assign wr_val     = bus_wdata[FIELD_W-1:0];
   assign wr_en_bits = bus_wdata[BUS_W-1:FIELD_W];

   generate
      for (genvar k = 0; k < NUM_CTRL; k++) begin : g_word
         pc_mask_reg #(
            .W      (FIELD_W),
            .RST_VAL('0)
         ) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bus_wr & ctrl_sel[k]),
            .din   (wr_val),
            .bit_en(wr_en_bits),
            .q     (ctrl_q[k])
         );
      end
   endgenerate

   // ---------------- status ----------------
   logic [ST_W-1:0] st_raw;
   logic [ST_W-1:0] st_sync;

   assign st_raw = {cal_done_async, dll_lock_async};

   pc_sync #(
      .W     (ST_W),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (st_raw),
      .q    (st_sync)
   );

   logic [FIELD_W-1:0] status_word;
   always_comb begin
      status_word              = '0;
      status_word[ST_CAL_BIT]  = st_sync[1];
      status_word[ST_LOCK_BIT] = st_sync[0];
   end

   // ---------------- readback ----------------
   logic [FIELD_W-1:0] rd_low;
   always_comb begin
      rd_low = '0;
      for (int k = 0; k < NUM_CTRL; k++) begin
         if (ctrl_sel[k]) begin
            rd_low = rd_low | ctrl_q[k];
         end
      end
      if (status_hit) begin
         rd_low = rd_low | status_word;
      end
   end

   assign bus_rdata = bus_rd ? {{(BUS_W-FIELD_W){1'b0}}, rd_low} : '0;

   // ---------------- field outputs ----------------
   assign pwr_up   = ctrl_q[IDX_POWER][PWR_BIT];
   assign dll_on   = ctrl_q[IDX_POWER][DLL_BIT];
   assign drv_code = ctrl_q[IDX_POWER][DRV_LSB +: DRV_W];
   assign tap_sel  = ctrl_q[IDX_TIMING][TAP_SEL_LSB +: TAP_SEL_W];
   assign tap_en   = ctrl_q[IDX_TIMING][TAP_EN_BIT];
   assign dll_band = ctrl_q[IDX_TIMING][BAND_LSB +: BAND_W];

   // ---------------- checks ----------------
   assert_single_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ctrl_sel) && !(status_hit && (ctrl_sel != '0)));

   assert_stray_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (ctrl_sel == '0)) |=> $stable(ctrl_q));

   assert_upper_half_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[BUS_W-1:FIELD_W] == '0);

endmodule

// File: tb/phy_ctl_bank_tb.sv
module phy_ctl_bank_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cal_done_async = 1'b0;
   logic        dll_lock_async = 1'b0;
   logic        pwr_up, dll_on, tap_en;
   logic [2:0]  drv_code;
   logic [3:0]  tap_sel;
   logic [1:0]  dll_band;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   phy_ctl_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cal_done_async(cal_done_async), .dll_lock_async(dll_lock_async),
      .pwr_up(pwr_up), .dll_on(dll_on), .drv_code(drv_code),
      .tap_sel(tap_sel), .tap_en(tap_en), .dll_band(dll_band)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   function automatic logic [15:0] pattern(input int k);
      return 16'h0100 + 16'(k * 16'h0111);
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      for (int k = 0; k < 7; k++) begin
         rd(6'(k * 4), v);
         check("R6 word clear", v, 32'h0);
      end
      check("R6 outputs clear", {20'h0, pwr_up, dll_on, drv_code, tap_sel, tap_en, dll_band}, 32'h0);
   endtask

   task automatic t_masked();
      logic [31:0] v;
      wr(6'h0C, 32'hFFFF_A5A5);
      rd(6'h0C, v);
      check("R1 full write", v, 32'h0000_A5A5);
      wr(6'h0C, 32'h00F0_0F0F);
      rd(6'h0C, v);
      check("R1 partial write", v, 32'h0000_A505);
      wr(6'h0C, 32'h0000_FFFF);
      rd(6'h0C, v);
      check("R1 zero mask", v, 32'h0000_A505);
      check("R3 upper zero", {16'h0, v[31:16]}, 32'h0);
   endtask

   task automatic t_decode();
      logic [31:0] v;
      for (int k = 0; k < 7; k++) wr(6'(k * 4), {16'hFFFF, pattern(k)});
      for (int k = 0; k < 7; k++) begin
         rd(6'(k * 4), v);
         check("R2 word map", v, {16'h0, pattern(k)});
      end
      wr(6'h00, 32'hFFFF_0000);
      wr(6'h18, 32'hFFFF_0000);
   endtask

   task automatic t_fields();
      wr(6'h18, 32'h0073_0043);
      check("R7 power up", {31'h0, pwr_up}, 32'h1);
      check("R7 dll enable", {31'h0, dll_on}, 32'h1);
      check("R7 drive 40 ohm", {29'h0, drv_code}, 32'h4);
      wr(6'h00, 32'h3F80_2C80);
      check("R8 tap select", {28'h0, tap_sel}, 32'h9);
      check("R8 tap enable", {31'h0, tap_en}, 32'h1);
      check("R8 band 100M", {30'h0, dll_band}, 32'h2);
      wr(6'h00, 32'h3000_1000);
      check("R8 band 50M", {30'h0, dll_band}, 32'h1);
      check("R8 tap kept", {27'h0, tap_en, tap_sel}, 32'h19);
      wr(6'h18, 32'h0001_0000);
      check("R7 power down only", {26'h0, drv_code, 1'b0, dll_on, pwr_up}, 32'h22);
   endtask

   task automatic t_ignore();
      logic [31:0] v;
      logic [6:0][15:0] snap;
      logic [12:0] outs;
      for (int k = 0; k < 7; k++) begin
         rd(6'(k * 4), v);
         snap[k] = v[15:0];
      end
      outs = {pwr_up, dll_on, drv_code, tap_sel, tap_en, dll_band, 1'b0};
      wr(6'h20, 32'hFFFF_FFFF);
      wr(6'h1C, 32'hFFFF_FFFF);
      wr(6'h24, 32'hFFFF_FFFF);
      wr(6'h02, 32'hFFFF_FFFF);
      wr(6'h19, 32'hFFFF_FFFF);
      for (int k = 0; k < 7; k++) begin
         rd(6'(k * 4), v);
         check("R5 stray write", v, {16'h0, snap[k]});
      end
      check("R5 outputs held", {19'h0, pwr_up, dll_on, drv_code, tap_sel, tap_en, dll_band, 1'b0},
            {19'h0, outs});
      rd(6'h20, v);
      check("R5 status unchanged", v, 32'h0);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      rd(6'h1C, v); check("R9 hole 0x1C", v, 32'h0);
      rd(6'h24, v); check("R9 hole 0x24", v, 32'h0);
      rd(6'h19, v); check("R9 unaligned", v, 32'h0);
      rd(6'h3C, v); check("R9 top", v, 32'h0);
   endtask

   task automatic t_status();
      logic [31:0] v;
      @(negedge clk);
      cal_done_async = 1'b1;
      rd(6'h20, v);
      check("R4 one edge", v, 32'h0);
      rd(6'h20, v);
      check("R4 cal done", v, 32'h40);
      @(negedge clk);
      dll_lock_async = 1'b1;
      rd(6'h20, v);
      check("R4 lock one edge", v, 32'h40);
      rd(6'h20, v);
      check("R4 both", v, 32'h60);
      @(negedge clk);
      cal_done_async = 1'b0;
      rd(6'h20, v);
      rd(6'h20, v);
      check("R4 lock only", v, 32'h20);
   endtask

   task automatic t_same_cycle();
      logic [31:0] v;
      wr(6'h08, 32'hFFFF_1234);
      @(negedge clk);
      bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 6'h08; bus_wdata = 32'hFFFF_BEEF;
      #1 v = bus_rdata;
      check("R10 old value", v, 32'h1234);
      @(negedge clk);
      bus_wr = 1'b0;
      #1 v = bus_rdata;
      check("R10 new value", v, 32'hBEEF);
      bus_rd = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_masked();
      t_decode();
      t_fields();
      t_ignore();
      t_unmapped();
      t_status();
      t_same_cycle();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule